// File: doc/BRIEF.md
# USB Link Power Management Handshake and Resume Controller

This block holds the link power management logic of a USB device controller. The packet decoder gives it a one-cycle strobe for each link power management token. The endpoint logic gives it one non-empty flag per transmit FIFO. A two-bit software enable field, a software "ready to suspend" bit and the live FIFO flags together pick the handshake for each token: none (the host times out), STALL, NYET or ACK. Every handshake actually sent sets a sticky interrupt bit.

An ACKed token puts the device into the suspended state. While suspended, software can ask that every ordinary token be answered with NAK. That request stays in force after resume until software withdraws it. Software can also start a remote wakeup. The block then drives resume signalling for a fixed number of microseconds and waits for the host's answering resume. When any host-driven resume ends, the block waits a short settle interval, goes back to normal operation and sets the resume interrupt bit.

All intervals are counted in microseconds from a tick divided down from the block clock, with the clock rate in MHz given as a parameter.

Top module: `usb_lpm_ctrl`

## Requirements
- R1: With an enable field of 0 or 2, an LPM token gets no handshake (`hs_valid` stays 0) and no interrupt bit is set, whatever `cfg_ready` and the FIFO flags are.
- R2: With an enable field of 1, every LPM token gets STALL (`hs_code` = 1), whatever `cfg_ready` and the FIFO flags are.
- R3: With an enable field of 3 and `cfg_ready` = 0, the reply is NYET (`hs_code` = 2).
- R4: With an enable field of 3 and `cfg_ready` = 1, the reply is ACK (`hs_code` = 3) only when every bit of `tx_nonempty` is 0. Otherwise it is NYET.
- R5: The handshake is a one-cycle `hs_valid` pulse in the cycle after the token. Each pulse sets `irq_lpm` in that same cycle, and the bit stays set.
- R6: Only an ACK moves the block into suspend. `suspended` rises together with the ACK pulse. NYET and STALL leave it at 0.
- R7: `force_nak` rises only when the block enters suspend, or is already suspended, while `cfg_nak_all` = 1. It stays at 1 through resume and falls one cycle after `cfg_nak_all` is cleared.
- R8: A `rwake_wr` strobe while suspended and idle raises `resume_drive` for exactly RWAKE_US × CLK_MHZ cycles, after which it clears itself.
- R9: A `rwake_wr` strobe while not suspended is ignored: `resume_drive` stays 0 and `suspended` is unchanged.
- R10: When `host_resume` falls after a host resume or after a remote wakeup, `suspended` stays 1 for exactly SETTLE_US × CLK_MHZ more cycles. It then drops to 0 in the same cycle that `irq_resume` becomes 1.
- R11: A 1 on `irq_clr[0]` clears `irq_lpm` and a 1 on `irq_clr[1]` clears `irq_resume`. When a set and a clear arrive in the same cycle, the set wins.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| lpm_tok | input | 1 | One-cycle strobe: LPM token decoded |
| tx_nonempty | input | NUM_TX | Per transmit FIFO: holds data |
| cfg_lpm_en | input | 2 | Link power management enable field |
| cfg_ready | input | 1 | Software ready to suspend |
| cfg_nak_all | input | 1 | NAK every ordinary token once suspended |
| rwake_wr | input | 1 | Strobe: software writes 1 to remote wakeup |
| host_resume | input | 1 | Host is driving resume on the bus |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 LPM, bit 1 resume |
| hs_valid | output | 1 | Handshake to send this cycle |
| hs_code | output | 2 | 1 STALL, 2 NYET, 3 ACK (0 when idle) |
| suspended | output | 1 | Device is in LPM suspend or resuming |
| force_nak | output | 1 | Answer ordinary tokens with NAK |
| resume_drive | output | 1 | Drive resume signalling; also the remote-wakeup bit readback |
| irq_lpm | output | 1 | Sticky raw interrupt: LPM handshake sent |
| irq_resume | output | 1 | Sticky raw interrupt: resume finished |

## Verification
The handshake, `irq_lpm` and any entry into suspend are due in the cycle after the token edge, so each check samples at the first falling edge after the strobe is dropped. `resume_drive` rises at the edge that samples `rwake_wr`, and `suspended` falls exactly SETTLE_US × CLK_MHZ edges after the edge that samples `host_resume` low. The bench counts falling-edge samples of each level and compares the count with the cycle total that follows from the parameters. Ignored writes and the NAK persistence are checked by sampling the outputs one cycle after the stimulus and again before the next one.

// File: rtl/usb_lpm_pkg.sv
package usb_lpm_pkg;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_STALL = 2'd1,
    HS_NYET  = 2'd2,
    HS_ACK   = 2'd3
  } lpm_hs_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SUSP,
    ST_RWAKE,
    ST_WAIT_HOST,
    ST_HOST_RES,
    ST_SETTLE
  } lpm_st_e;

  // Handshake decision from enable field, ready bit and FIFO occupancy
  function automatic lpm_hs_e pick_hs(input logic [1:0] en,
                                      input logic ready,
                                      input logic pend);
    lpm_hs_e r;
    case (en)
      2'd1:    r = HS_STALL;
      2'd3:    r = (ready && !pend) ? HS_ACK : HS_NYET;
      default: r = HS_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lpm_resp_sel.sv
module lpm_resp_sel
  import usb_lpm_pkg::*;
#(
  parameter int NUM_TX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lpm_tok,
  input  logic [1:0]        lpm_en,
  input  logic              ready,
  input  logic [NUM_TX-1:0] tx_nonempty,
  output logic              ack_now,
  output logic              hs_valid,
  output logic [1:0]        hs_code
);

  lpm_hs_e choice;
  logic    any_pend;

  assign any_pend = |tx_nonempty;
  assign choice   = pick_hs(lpm_en, ready, any_pend);
  assign ack_now  = lpm_tok && (choice == HS_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
    end else begin
      hs_valid <= lpm_tok && (choice != HS_NONE);
      hs_code  <= lpm_tok ? choice : HS_NONE;
    end
  end

  // R1
  no_hs_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    lpm_tok && !lpm_en[0] |=> !hs_valid);
  // R2
  stall_reply_chk: assert property (@(posedge clk) disable iff (rst)
    lpm_tok && lpm_en == 2'd1 |=> hs_valid && hs_code == HS_STALL);
  // R3
  nyet_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    lpm_tok && lpm_en == 2'd3 && !ready |=> hs_valid && hs_code == HS_NYET);
  // R4
  nyet_pending_chk: assert property (@(posedge clk) disable iff (rst)
    lpm_tok && lpm_en == 2'd3 && (tx_nonempty != '0) |=> hs_code == HS_NYET);
  // R5
  hs_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hs_valid && !$past(lpm_tok) |-> 1'b0);

endmodule

// File: rtl/lpm_us_timer.sv
module lpm_us_timer #(
  parameter int CLK_MHZ = 125,
  parameter int UW      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [UW-1:0] load_us,
  output logic          done
);

  localparam int PW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_MHZ - 1);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;
  logic          run_q;
  logic          wrap;

  assign wrap = (pre_q == PRE_LAST);
  assign done = run_q && wrap && (us_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      pre_q <= '0;
      us_q  <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      pre_q <= '0;
      us_q  <= load_us - 1'b1;
    end else if (run_q) begin
      if (wrap) begin
        pre_q <= '0;
        if (us_q == '0) run_q <= 1'b0;
        else            us_q  <= us_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R8
  timer_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> load_us != '0);
  // R8
  timer_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> !run_q);

endmodule

// File: rtl/lpm_irq_bits.sv
module lpm_irq_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> q[i]);
    // R11
    clr_works_chk: assert property (@(posedge clk) disable iff (rst)
      clr[i] && !set[i] |=> !q[i]);
  end

endmodule

// File: rtl/usb_lpm_ctrl.sv
module usb_lpm_ctrl
  import usb_lpm_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int NUM_TX    = 4,
  parameter int RWAKE_US  = 50,
  parameter int SETTLE_US = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lpm_tok,
  input  logic [NUM_TX-1:0] tx_nonempty,
  input  logic [1:0]        cfg_lpm_en,
  input  logic              cfg_ready,
  input  logic              cfg_nak_all,
  input  logic              rwake_wr,
  input  logic              host_resume,
  input  logic [1:0]        irq_clr,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic              suspended,
  output logic              force_nak,
  output logic              resume_drive,
  output logic              irq_lpm,
  output logic              irq_resume
);

  localparam int MAX_US = (RWAKE_US > SETTLE_US) ? RWAKE_US : SETTLE_US;
  localparam int UW     = $clog2(MAX_US + 1);

  lpm_st_e       st_q, st_d;
  logic          ack_now;
  logic          tmr_start;
  logic [UW-1:0] tmr_load;
  logic          tmr_done;
  logic          set_res;
  logic [1:0]    irq_q;

  lpm_resp_sel #(.NUM_TX(NUM_TX)) u_resp (
    .clk        (clk),
    .rst        (rst),
    .lpm_tok    (lpm_tok),
    .lpm_en     (cfg_lpm_en),
    .ready      (cfg_ready),
    .tx_nonempty(tx_nonempty),
    .ack_now    (ack_now),
    .hs_valid   (hs_valid),
    .hs_code    (hs_code)
  );

  lpm_us_timer #(.CLK_MHZ(CLK_MHZ), .UW(UW)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .start  (tmr_start),
    .load_us(tmr_load),
    .done   (tmr_done)
  );

  always_comb begin
    st_d      = st_q;
    tmr_start = 1'b0;
    tmr_load  = '0;
    set_res   = 1'b0;
    case (st_q)
      ST_RUN:
        if (ack_now) st_d = ST_SUSP;
      ST_SUSP:
        if (rwake_wr) begin
          st_d      = ST_RWAKE;
          tmr_start = 1'b1;
          tmr_load  = UW'(RWAKE_US);
        end else if (host_resume) begin
          st_d = ST_HOST_RES;
        end
      ST_RWAKE:
        if (tmr_done) st_d = ST_WAIT_HOST;
      ST_WAIT_HOST:
        if (host_resume) st_d = ST_HOST_RES;
      ST_HOST_RES:
        if (!host_resume) begin
          st_d      = ST_SETTLE;
          tmr_start = 1'b1;
          tmr_load  = UW'(SETTLE_US);
        end
      ST_SETTLE:
        if (tmr_done) begin
          st_d    = ST_RUN;
          set_res = 1'b1;
        end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_RUN;
      suspended    <= 1'b0;
      resume_drive <= 1'b0;
      force_nak    <= 1'b0;
    end else begin
      st_q         <= st_d;
      suspended    <= (st_d != ST_RUN);
      resume_drive <= (st_d == ST_RWAKE);
      force_nak    <= cfg_nak_all && (force_nak || (st_d != ST_RUN));
    end
  end

  lpm_irq_bits #(.N(2)) u_irq (
    .clk(clk),
    .rst(rst),
    .set({set_res, hs_valid_next()}),
    .clr(irq_clr),
    .q  (irq_q)
  );

  function automatic logic hs_valid_next();
    return lpm_tok && cfg_lpm_en[0];
  endfunction

  assign irq_lpm    = irq_q[0];
  assign irq_resume = irq_q[1];

  // R5
  irq_with_hs_chk: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> irq_lpm);
  // R6
  suspend_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(suspended) |-> hs_valid && hs_code == HS_ACK);
  // R7
  nak_after_suspend_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(force_nak) |-> suspended);
  // R7
  nak_release_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_nak_all |=> !force_nak);
  // R8
  drive_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(resume_drive) |-> st_q == ST_WAIT_HOST);
  // R9
  rwake_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    rwake_wr && st_q != ST_SUSP |=> !$rose(resume_drive));
  // R10
  resume_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(suspended) |-> irq_resume);

endmodule

// File: tb/tb_usb_lpm_ctrl.sv
`timescale 1ns/1ps
module tb_usb_lpm_ctrl;

  localparam int CLK_MHZ   = 125;
  localparam int NUM_TX    = 4;
  localparam int RWAKE_US  = 50;
  localparam int SETTLE_US = 10;
  localparam int RWAKE_CYC  = RWAKE_US * CLK_MHZ;
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lpm_tok = 1'b0;
  logic [NUM_TX-1:0] tx_nonempty = '0;
  logic [1:0] cfg_lpm_en = 2'd0;
  logic cfg_ready = 1'b0;
  logic cfg_nak_all = 1'b0;
  logic rwake_wr = 1'b0;
  logic host_resume = 1'b0;
  logic [1:0] irq_clr = 2'b00;
  logic hs_valid, suspended, force_nak, resume_drive, irq_lpm, irq_resume;
  logic [1:0] hs_code;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  usb_lpm_ctrl #(
    .CLK_MHZ(CLK_MHZ), .NUM_TX(NUM_TX),
    .RWAKE_US(RWAKE_US), .SETTLE_US(SETTLE_US)
  ) dut (
    .clk(clk), .rst(rst), .lpm_tok(lpm_tok), .tx_nonempty(tx_nonempty),
    .cfg_lpm_en(cfg_lpm_en), .cfg_ready(cfg_ready), .cfg_nak_all(cfg_nak_all),
    .rwake_wr(rwake_wr), .host_resume(host_resume), .irq_clr(irq_clr),
    .hs_valid(hs_valid), .hs_code(hs_code), .suspended(suspended),
    .force_nak(force_nak), .resume_drive(resume_drive),
    .irq_lpm(irq_lpm), .irq_resume(irq_resume)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_tok();
    lpm_tok = 1'b1;
    @(negedge clk) lpm_tok = 1'b0;
  endtask

  task automatic clear_irqs();
    irq_clr = 2'b11;
    @(negedge clk) irq_clr = 2'b00;
  endtask

  task automatic t_reset();
    check("R12 hs_valid", hs_valid, 0);
    check("R12 suspended", suspended, 0);
    check("R12 outputs", {force_nak, resume_drive, irq_lpm, irq_resume, hs_code}, 0);
  endtask

  task automatic t_timeout();
    for (int e = 0; e < 4; e += 2) begin
      for (int k = 0; k < 4; k++) begin
        cfg_lpm_en = 2'(e); cfg_ready = k[0]; tx_nonempty = k[1] ? 4'b0100 : 4'b0000;
        send_tok();
        check("R1 no handshake", hs_valid, 0);
        check("R1 R5 no irq", irq_lpm, 0);
      end
    end
  endtask

  task automatic t_stall();
    cfg_lpm_en = 2'd1; cfg_ready = 1'b1; tx_nonempty = '0;
    send_tok();
    check("R2 stall valid", hs_valid, 1);
    check("R2 stall code", hs_code, 1);
    check("R5 irq_lpm set", irq_lpm, 1);
    check("R6 no suspend on stall", suspended, 0);
    @(negedge clk);
    check("R5 one-cycle pulse", hs_valid, 0);
    check("R5 irq sticky", irq_lpm, 1);
    irq_clr = 2'b01;
    @(negedge clk) irq_clr = 2'b00;
    check("R11 clear irq_lpm", irq_lpm, 0);
  endtask

  task automatic t_nyet();
    cfg_lpm_en = 2'd3; cfg_ready = 1'b0; tx_nonempty = '0;
    send_tok();
    check("R3 nyet code", hs_code, 2);
    check("R6 no suspend on nyet", suspended, 0);
    cfg_ready = 1'b1; tx_nonempty = 4'b1000;
    send_tok();
    check("R4 pending gives nyet", hs_code, 2);
    check("R4 no suspend", suspended, 0);
    clear_irqs();
  endtask

  task automatic t_rwake_ignored();
    rwake_wr = 1'b1;
    @(negedge clk) rwake_wr = 1'b0;
    check("R9 drive stays low", resume_drive, 0);
    @(negedge clk);
    check("R9 still low", resume_drive, 0);
    check("R9 not suspended", suspended, 0);
  endtask

  task automatic t_ack_nak();
    cfg_nak_all = 1'b1;
    @(negedge clk);
    check("R7 no nak before suspend", force_nak, 0);
    cfg_lpm_en = 2'd3; cfg_ready = 1'b1; tx_nonempty = '0;
    send_tok();
    check("R4 ack code", hs_code, 3);
    check("R6 suspended on ack", suspended, 1);
    check("R7 nak after suspend", force_nak, 1);
  endtask

  task automatic host_resume_and_settle(input string req);
    int n = 0;
    host_resume = 1'b1;
    repeat (20) @(negedge clk);
    check({req, " suspended during host resume"}, suspended, 1);
    host_resume = 1'b0;
    @(negedge clk);
    while (suspended && n < 3 * SETTLE_CYC) begin
      n++;
      @(negedge clk);
    end
    check({req, " settle cycles"}, n, SETTLE_CYC);
    check({req, " irq_resume"}, irq_resume, 1);
  endtask

  task automatic t_host_resume();
    host_resume_and_settle("R10");
    check("R7 nak persists", force_nak, 1);
    cfg_nak_all = 1'b0;
    @(negedge clk);
    check("R7 nak released", force_nak, 0);
  endtask

  task automatic t_rwake();
    int n = 0;
    clear_irqs();
    send_tok();
    check("R6 suspended again", suspended, 1);
    check("R7 no nak when disabled", force_nak, 0);
    rwake_wr = 1'b1;
    @(negedge clk) rwake_wr = 1'b0;
    while (resume_drive && n < 3 * RWAKE_CYC) begin
      n++;
      @(negedge clk);
    end
    check("R8 drive cycles", n, RWAKE_CYC);
    check("R8 self clear", resume_drive, 0);
    check("R8 still suspended", suspended, 1);
    host_resume_and_settle("R10 after wakeup");
  endtask

  task automatic t_set_wins();
    cfg_lpm_en = 2'd1;
    irq_clr = 2'b01;
    send_tok();
    irq_clr = 2'b00;
    check("R11 set wins", irq_lpm, 1);
    irq_clr = 2'b10;
    @(negedge clk) irq_clr = 2'b00;
    check("R11 clear resume", irq_resume, 0);
    check("R11 lpm untouched", irq_lpm, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timeout();
    t_stall();
    t_nyet();
    t_rwake_ignored();
    t_ack_nak();
    t_host_resume();
    t_rwake();
    t_set_wins();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule